// File: doc/BRIEF.md
# Multiphase Beam-Weighted Vector Decoder

This block turns a requested amplitude and phase into drive codes for a multiphase digital transmitter. Sixteen evenly spaced clock phases are assumed to exist elsewhere. The decoder picks the adjacent pair that brackets the requested angle. It then computes two integer weights that tell a capacitor array how many cells switch on each phase of the pair. The sum of the two phases, each scaled by its weight, reconstructs the requested vector.

A per-channel beam weight (an amplitude factor and a phase offset) is stored inside the block. A sample issued with the load flag set becomes the new beam weight and is also decoded as it is. A sample issued with the flag clear is a modulation sample. Its envelope is scaled by the stored beam amplitude and its phase is advanced by the stored beam phase, so beam steering and modulation share one encoder. Phase is an unsigned fraction of a full turn, so the offset addition wraps naturally. Results leave a three-stage pipeline with a valid flag, and the phase index and both weights are aligned on the same cycle.

Top module: `mpbf_decoder`

## Requirements
- R1: While rst_ni is low and after it rises, valid_o, sel_o, n1_o and n2_o are 0. The stored beam weight resets to amplitude 16'hFFFF and phase 16'h0000.
- R2: A sample accepted with valid_i high at a rising edge produces valid_o high for exactly one cycle, after the third rising edge counting the accepting edge. Samples on consecutive edges come out on consecutive cycles in order.
- R3: On every valid output, n1_o + n2_o is at most 2^K (512 with defaults).
- R4: sel_o is bits [15:12] of the total phase and names the lower phase of the pair. The pair is sel_o and (sel_o+1) mod 16, spaced 22.5 degrees apart. A total of 210 degrees gives sel_o = 9 (202.5 and 225 degrees).
- R5: For a sample with load_i low, the total amplitude is (amp_i * beam_amp) >> 16, truncated. A zero envelope gives both weights 0.
- R6: For a sample with load_i high, amp_i and ph_i are stored as the beam weight. The same sample is decoded with total amplitude amp_i and total phase ph_i.
- R7: Let idx be bits [11:7] of the total phase and d = 22.5 degrees. The weights are n2 = round(A/65536 * cos(d/2) * sin(d*idx/32) / sin(d) * 512) and n1 = the same with idx replaced by 32-idx, each within one LSB. n1_o weights phase sel_o and n2_o weights phase sel_o+1.
- R8: With valid_i low, load_i and the data inputs have no effect. The outputs hold their last values and the stored beam weight is unchanged.
- R9: For a sample with load_i low, the total phase is (ph_i + beam_ph) mod 2^16, so a sum past a full turn wraps to the start of the circle.
- R10: A total phase on a sector boundary (idx = 0) gives n2_o = 0 exactly, with n1_o carrying the whole amplitude scaled by cos(d/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| load_i | input | 1 | Sample is a new beam weight |
| amp_i | input | 16 | Amplitude, unsigned fraction of full scale |
| ph_i | input | 16 | Phase, unsigned fraction of a full turn |
| valid_o | output | 1 | Output result strobe |
| sel_o | output | 4 | Index of the lower phase of the selected pair |
| n1_o | output | 10 | Weight for phase sel_o |
| n2_o | output | 10 | Weight for phase sel_o+1 |

## Verification
A corrupted stored beam weight does not show on the sample that loads it. It appears three cycles after the next modulation sample, as a wrong sel_o or weight pair. The bench therefore always follows a load with dependent samples. A pipeline stage that drops its enable or captures idle inputs shows up as drifting outputs while valid_o is low, or as a valid pulse on the wrong cycle. Back-to-back issue and idle stretches check both of these. A wrong sine table entry or a swapped pair shows as a weight that misses its expected value by more than one LSB. It is visible on the first result that lands in the affected fine position.

// File: rtl/mpbf_pkg.sv
package mpbf_pkg;
  localparam real PI = 3.141592653589793;

  // Scaled interpolation factor cos(pi/nph)*sin(step*i/lut_n)/sin(step)
  function automatic int coef_f(input int i, input int lut_n, input int nph, input int cf);
    real step;
    real v;
    step = 2.0 * PI / nph;
    v = $cos(PI / nph) * $sin(step * i / lut_n) / $sin(step);
    return $rtoi(v * (2.0 ** cf) + 0.5);
  endfunction
endpackage

// File: rtl/mpbf_combine.sv
module mpbf_combine #(
  parameter int PH_W  = 16,
  parameter int AMP_W = 16,
  parameter int PQ_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             load_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [PH_W-1:0]  ph_i,
  output logic             vld_o,
  output logic [AMP_W-1:0] amp_o,
  output logic [PQ_W-1:0]  ph_o
);
  logic [AMP_W-1:0] beam_amp_q;
  logic [PH_W-1:0]  beam_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beam_amp_q <= '1;
      beam_ph_q  <= '0;
      vld_o      <= 1'b0;
      amp_o      <= '0;
      ph_o       <= '0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        if (load_i) begin
          beam_amp_q <= amp_i;
          beam_ph_q  <= ph_i;
          amp_o      <= amp_i;
          ph_o       <= ph_i[PH_W-1 -: PQ_W];
        end else begin
          amp_o <= AMP_W'(({{AMP_W{1'b0}}, amp_i} * {{AMP_W{1'b0}}, beam_amp_q}) >> AMP_W);
          // modulo-turn phase: carry out of the top bit is dropped
          ph_o  <= PQ_W'(PH_W'(ph_i + beam_ph_q) >> (PH_W - PQ_W));
        end
      end
    end
  end
endmodule

// File: rtl/mpbf_coef_lut.sv
module mpbf_coef_lut #(
  parameter int AMP_W  = 16,
  parameter int SEL_W  = 4,
  parameter int LUT_AW = 5,
  parameter int CF_W   = 14,
  localparam int NPH   = 2 ** SEL_W,
  localparam int LUT_N = 2 ** LUT_AW,
  localparam int CO_W  = CF_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic [SEL_W+LUT_AW-1:0] ph_i,
  output logic                    vld_o,
  output logic [AMP_W-1:0]        amp_o,
  output logic [SEL_W-1:0]        sel_o,
  output logic [CO_W-1:0]         coef_a_o,
  output logic [CO_W-1:0]         coef_b_o
);
  logic [CO_W-1:0]   lut [LUT_N+1];
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW:0]   idx_a;

  for (genvar g = 0; g <= LUT_N; g++) begin : g_lut
    assign lut[g] = CO_W'(mpbf_pkg::coef_f(g, LUT_N, NPH, CF_W));
  end

  assign idx   = ph_i[LUT_AW-1:0];
  assign idx_a = (LUT_AW+1)'(LUT_N) - {1'b0, idx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      amp_o    <= '0;
      sel_o    <= '0;
      coef_a_o <= '0;
      coef_b_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        amp_o    <= amp_i;
        sel_o    <= ph_i[SEL_W+LUT_AW-1 -: SEL_W];
        coef_a_o <= lut[idx_a];
        coef_b_o <= lut[idx];
      end
    end
  end
endmodule

// File: rtl/mpbf_weight.sv
module mpbf_weight #(
  parameter int AMP_W = 16,
  parameter int SEL_W = 4,
  parameter int CF_W  = 14,
  parameter int K     = 9,
  localparam int CO_W = CF_W + 1,
  localparam int WT_W = K + 1,
  localparam int PW   = AMP_W + CO_W,
  localparam int SH   = AMP_W + CF_W - K
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CO_W-1:0]  coef_a_i,
  input  logic [CO_W-1:0]  coef_b_i,
  output logic             vld_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [WT_W-1:0]  n1_o,
  output logic [WT_W-1:0]  n2_o
);
  localparam logic [PW-1:0]   FULL_P = PW'(2 ** K);
  localparam logic [WT_W-1:0] FULL_W = WT_W'(2 ** K);
  localparam logic [PW-1:0]   RND    = PW'(1) << (SH - 1);

  logic [PW-1:0]   ra, rb;
  logic [WT_W-1:0] na, nb, na_s;
  logic [WT_W:0]   sum;

  assign ra  = (PW'(amp_i) * PW'(coef_a_i) + RND) >> SH;
  assign rb  = (PW'(amp_i) * PW'(coef_b_i) + RND) >> SH;
  assign na  = (ra > FULL_P) ? FULL_W : ra[WT_W-1:0];
  assign nb  = (rb > FULL_P) ? FULL_W : rb[WT_W-1:0];
  assign sum = {1'b0, na} + {1'b0, nb};
  // trim the leading weight if rounding pushed the pair past full scale
  assign na_s = (sum > {1'b0, FULL_W}) ? (FULL_W - nb) : na;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      sel_o <= '0;
      n1_o  <= '0;
      n2_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sel_o <= sel_i;
        n1_o  <= na_s;
        n2_o  <= nb;
      end
    end
  end
endmodule

// File: rtl/mpbf_decoder.sv
module mpbf_decoder #(
  parameter int PH_W   = 16,
  parameter int AMP_W  = 16,
  parameter int SEL_W  = 4,
  parameter int LUT_AW = 5,
  parameter int CF_W   = 14,
  parameter int K      = 9,
  localparam int PQ_W  = SEL_W + LUT_AW,
  localparam int CO_W  = CF_W + 1,
  localparam int WT_W  = K + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             load_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [PH_W-1:0]  ph_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [WT_W-1:0]  n1_o,
  output logic [WT_W-1:0]  n2_o
);
  logic             s1_vld, s2_vld;
  logic [AMP_W-1:0] s1_amp, s2_amp;
  logic [PQ_W-1:0]  s1_ph;
  logic [SEL_W-1:0] s2_sel;
  logic [CO_W-1:0]  s2_ca, s2_cb;

  mpbf_combine #(.PH_W(PH_W), .AMP_W(AMP_W), .PQ_W(PQ_W)) u_combine (
    .clk_i, .rst_ni, .valid_i, .load_i, .amp_i, .ph_i,
    .vld_o(s1_vld), .amp_o(s1_amp), .ph_o(s1_ph)
  );

  mpbf_coef_lut #(.AMP_W(AMP_W), .SEL_W(SEL_W), .LUT_AW(LUT_AW), .CF_W(CF_W)) u_lut (
    .clk_i, .rst_ni, .vld_i(s1_vld), .amp_i(s1_amp), .ph_i(s1_ph),
    .vld_o(s2_vld), .amp_o(s2_amp), .sel_o(s2_sel), .coef_a_o(s2_ca), .coef_b_o(s2_cb)
  );

  mpbf_weight #(.AMP_W(AMP_W), .SEL_W(SEL_W), .CF_W(CF_W), .K(K)) u_weight (
    .clk_i, .rst_ni, .vld_i(s2_vld), .amp_i(s2_amp), .sel_i(s2_sel),
    .coef_a_i(s2_ca), .coef_b_i(s2_cb),
    .vld_o(valid_o), .sel_o, .n1_o, .n2_o
  );
endmodule

// File: rtl/mpbf_decoder_chk.sv
module mpbf_decoder_chk #(
  parameter int AMP_W = 16,
  parameter int SEL_W = 4,
  parameter int K     = 9,
  localparam int WT_W = K + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [AMP_W-1:0] amp_i,
  input logic             valid_o,
  input logic [SEL_W-1:0] sel_o,
  input logic [WT_W-1:0]  n1_o,
  input logic [WT_W-1:0]  n2_o
);
  localparam logic [WT_W:0] FULL = (WT_W+1)'(2 ** K);

  p_sum_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (({1'b0, n1_o} + {1'b0, n2_o}) <= FULL));

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sel_o) && $stable(n1_o) && $stable(n2_o)));

  p_zero_amp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amp_i == '0) |-> ##3 (n1_o == '0 && n2_o == '0));
endmodule

bind mpbf_decoder mpbf_decoder_chk #(.AMP_W(AMP_W), .SEL_W(SEL_W), .K(K)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .amp_i(amp_i),
  .valid_o(valid_o), .sel_o(sel_o), .n1_o(n1_o), .n2_o(n2_o)
);

// File: tb/mpbf_decoder_bench.sv
module mpbf_decoder_bench;
  localparam real PI = 3.141592653589793;
  localparam real D  = 2.0 * PI / 16.0;
  localparam int  NV = 10;
  // {load, amp, phase}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h8000, 16'h0000},
    {1'b0, 16'hFFFF, 16'h1000},
    {1'b1, 16'hC000, 16'h1555},
    {1'b0, 16'hFFFF, 16'h8000},
    {1'b0, 16'h4000, 16'hF000},
    {1'b0, 16'h0000, 16'h2345},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b0, 16'hFFFF, 16'h0800},
    {1'b0, 16'hFFFF, 16'h3FFF},
    {1'b1, 16'h2000, 16'h7000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni, valid_i, load_i;
  logic [15:0] amp_i, ph_i;
  logic        valid_o;
  logic [3:0]  sel_o;
  logic [9:0]  n1_o, n2_o;
  int          n_run = 0, n_fail = 0;
  longint      bamp_m = 65535, bph_m = 0;
  string       tags [NV];

  always #5 clk_i = ~clk_i;

  mpbf_decoder u_mpbf_decoder (
    .clk_i, .rst_ni, .valid_i, .load_i, .amp_i, .ph_i,
    .valid_o, .sel_o, .n1_o, .n2_o
  );

  function automatic real wt(input longint a, input int c);
    return (a / 65536.0) * $cos(PI / 16.0) * $sin(D * c / 32.0) / $sin(D) * 512.0;
  endfunction

  task automatic model(input logic ld, input logic [15:0] amp, input logic [15:0] ph,
                       output int es, output real r1, output real r2);
    longint a, p;
    int idx;
    if (ld) begin
      a = amp; p = ph; bamp_m = amp; bph_m = ph;
    end else begin
      a = (longint'(amp) * bamp_m) >> 16;
      p = (longint'(ph) + bph_m) % 65536;
    end
    es  = int'(p >> 12);
    idx = int'((p >> 7) & 31);
    r1  = wt(a, 32 - idx);
    r2  = wt(a, idx);
  endtask

  task automatic chk(input string req, input int act, input int exp, input int tol);
    n_run++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_res(input string ctx, input int es, input real r1, input real r2);
    chk({ctx, " R2 valid"}, int'(valid_o), 1, 0);
    chk({ctx, " R4 sel"}, int'(sel_o), es, 0);
    chk({ctx, " R7 n1"}, int'(n1_o), $rtoi(r1 + 0.5), 1);
    chk({ctx, " R7 n2"}, int'(n2_o), $rtoi(r2 + 0.5), 1);
    chk({ctx, " R3 sum"}, (int'(n1_o) + int'(n2_o) <= 512) ? 1 : 0, 1, 0);
    if (r2 == 0.0) chk({ctx, " R10 edge n2"}, int'(n2_o), 0, 0);
  endtask

  task automatic run_one(input logic ld, input logic [15:0] amp, input logic [15:0] ph,
                         input string ctx);
    int es;
    real r1, r2;
    @(negedge clk_i);
    valid_i = 1'b1; load_i = ld; amp_i = amp; ph_i = ph;
    model(ld, amp, ph, es, r1, r2);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    check_res(ctx, es, r1, r2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int   es_a [3];
    real  r1_a [3], r2_a [3];
    int   h_sel, h_n1, h_n2;
    tags = '{"R1 default beam", "R7 mid sector", "R6 load", "R4 R5 210deg",
             "R9 wrap", "R5 zero amp", "R6 R10 load edge", "R3 midpoint",
             "R7 top idx", "R6 load2"};
    rst_ni = 1'b0; valid_i = 1'b0; load_i = 1'b0; amp_i = '0; ph_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 valid in reset", int'(valid_o), 0, 0);
    chk("R1 n1 in reset", int'(n1_o), 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid", int'(valid_o), 0, 0);
    chk("R1 sel", int'(sel_o), 0, 0);
    chk("R1 n1", int'(n1_o), 0, 0);
    chk("R1 n2", int'(n2_o), 0, 0);

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][32], VEC[i][31:16], VEC[i][15:0], tags[i]);

    // R2: back-to-back samples with beam amp 0x2000, phase 0x7000
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; load_i = 1'b0; amp_i = 16'h4000 * (i + 1); ph_i = 16'h2100 * i;
      model(1'b0, amp_i, ph_i, es_a[i], r1_a[i], r2_a[i]);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check_res("R2 stream0", es_a[0], r1_a[0], r2_a[0]);
    @(negedge clk_i);
    check_res("R2 stream1", es_a[1], r1_a[1], r2_a[1]);
    @(negedge clk_i);
    check_res("R2 stream2", es_a[2], r1_a[2], r2_a[2]);
    @(negedge clk_i);
    chk("R2 single pulse", int'(valid_o), 0, 0);

    // R8: load and data without valid are ignored
    h_sel = int'(sel_o); h_n1 = int'(n1_o); h_n2 = int'(n2_o);
    load_i = 1'b1; amp_i = 16'h0000; ph_i = 16'h1234;
    repeat (5) @(negedge clk_i);
    chk("R8 valid idle", int'(valid_o), 0, 0);
    chk("R8 sel hold", int'(sel_o), h_sel, 0);
    chk("R8 n1 hold", int'(n1_o), h_n1, 0);
    chk("R8 n2 hold", int'(n2_o), h_n2, 0);
    run_one(1'b0, 16'hFFFF, 16'h0000, "R8 beam kept");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule